// File: doc/BRIEF.md
# In-Order Load Issue Arbiter

This block sits between three address-generation lanes and a pair of 64-bit memory access ports. In every cycle each lane may offer one memory operation whose address has just been computed, tagged with its program-order sequence number and with a flag that marks it as a read or a write. The arbiter picks at most two of these operations and places them on the two ports. Any mix of reads and writes can share a cycle.

Reads keep program order with respect to address resolution. A read may go out only when every older memory operation already has a known address. This holds even when the read's own address was ready early. There is no prediction that an unresolved older operation does not conflict. To know which older operations are still unresolved, dispatch registers each memory operation in a table when it enters a lane, on the allocate inputs. The entry is removed in the cycle the lane first offers that operation with its address. Writes are not held back by unresolved older operations.

Lane grants are combinational in the same cycle as the request, so a lane can advance at once. The chosen operations appear on the port registers one cycle later, with the older of the two on port 0. Sequence numbers carry one wrap bit above the table index, so ordering stays correct across a wrap of the counter. A flush input empties the table and suppresses all grants in its cycle.

Top module: `load_issue_arb`

## Requirements
- R1: While reset is held, and in the first cycle after it, all port valid bits and all lane grants are 0. The unresolved-address table is empty.
- R2: At most two lanes are granted in a cycle. Each granted operation appears on a port in the next cycle. The number of valid ports in a cycle equals the number of grants in the cycle before.
- R3: When both ports are valid, port 0 carries the older operation by sequence number. Port 1 is never valid while port 0 is idle.
- R4: Two writes, two reads, or one of each can be granted together in one cycle.
- R5: A read whose address is ready is not granted while any allocated operation older than it is still unresolved. An operation counts as resolved from the first cycle its lane offers it. A granted read never overtakes an older read that is offered in the same cycle.
- R6: A write is granted regardless of unresolved older operations.
- R7: When three operations are eligible, the two oldest are granted and the youngest waits for a later cycle.
- R8: Age comparison treats the top sequence bit as a wrap bit. For example, 5'b01111 is older than 5'b10000, both for port order and for blocking.
- R9: In a cycle with flush high, no lane is granted. From the next cycle on, no operation allocated before the flush blocks any read.
- R10: A port carries the granted lane's address, write data and sequence number. Its write flag is 1 for a write (request read flag 0) and 0 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Drops all unresolved entries and grants nothing this cycle |
| allocValid | input | LANES | Lane registers a new memory operation as unresolved |
| allocSeq | input | LANES x SEQ_W | Sequence number of the operation being registered |
| reqValid | input | LANES | Lane offers an address-ready operation |
| reqLoad | input | LANES | 1 = read, 0 = write |
| reqSeq | input | LANES x SEQ_W | Sequence number of the offered operation |
| reqAddr | input | LANES x ADDR_W | Access address |
| reqData | input | LANES x DATA_W | Write data (ignored for reads) |
| laneGrant | output | LANES | Lane's offer was accepted this cycle |
| portValid | output | 2 | Port holds an access |
| portWrite | output | 2 | Port access is a write |
| portAddr | output | 2 x ADDR_W | Port address |
| portData | output | 2 x DATA_W | Port write data |
| portSeq | output | 2 x SEQ_W | Port sequence number |

## Verification
Lane grants settle within the request cycle, so the bench drives on the falling edge and samples laneGrant one nanosecond later. Port contents pass through a single register, so they are compared at the next falling edge, after exactly one rising edge. An allocation takes effect at the rising edge that samples it, so it blocks reads from the following cycle. Each scenario follows that cadence and then drops its requests. This keeps every comparison in the cycle where the result must be present.

// File: rtl/load_issue_pkg.sv
package load_issue_pkg;
  localparam int ISSUE_PORTS = 2;
  localparam int LANE_ID_W = 2;

  typedef struct packed {
    logic [ISSUE_PORTS-1:0] take;
    logic [ISSUE_PORTS-1:0][LANE_ID_W-1:0] fromLane;
  } issueStrobes_t;

  // a older than b when (a - b) modulo 2**w has its top bit set
  function automatic logic seqOlder(input logic [31:0] a, input logic [31:0] b,
                                    input int unsigned w);
    logic [31:0] diff;
    diff = a - b;
    return diff[w-1];
  endfunction
endpackage

// File: rtl/load_issue_pend.sv
module load_issue_pend
  import load_issue_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SEQ_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic [LANES-1:0]              allocValid,
  input  logic [LANES-1:0][SEQ_W-1:0]   allocSeq,
  input  logic [LANES-1:0]              reqValid,
  input  logic [LANES-1:0][SEQ_W-1:0]   reqSeq,
  output logic [LANES-1:0]              olderPending
);
  localparam int IDX_W = SEQ_W - 1;
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] pendValid;
  logic [SEQ_W-1:0] pendSeq [DEPTH];
  logic [DEPTH-1:0] live;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pendValid <= '0;
      for (int k = 0; k < DEPTH; k++) pendSeq[k] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (reqValid[l] && pendValid[reqSeq[l][IDX_W-1:0]]
            && pendSeq[reqSeq[l][IDX_W-1:0]] == reqSeq[l])
          pendValid[reqSeq[l][IDX_W-1:0]] <= 1'b0;
      end
      for (int l = 0; l < LANES; l++) begin
        if (allocValid[l]) begin
          pendValid[allocSeq[l][IDX_W-1:0]] <= 1'b1;
          pendSeq[allocSeq[l][IDX_W-1:0]]   <= allocSeq[l];
        end
      end
    end
  end

  // an entry offered this cycle already has its address
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      live[k] = pendValid[k];
      for (int l = 0; l < LANES; l++)
        if (reqValid[l] && reqSeq[l] == pendSeq[k]) live[k] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      olderPending[i] = 1'b0;
      for (int k = 0; k < DEPTH; k++)
        if (live[k] && seqOlder(32'(pendSeq[k]), 32'(reqSeq[i]), SEQ_W))
          olderPending[i] = 1'b1;
    end
  end
endmodule

// File: rtl/load_issue_ctrl.sv
module load_issue_ctrl
  import load_issue_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SEQ_W = 5
) (
  input  logic                        flush,
  input  logic [LANES-1:0]            reqValid,
  input  logic [LANES-1:0]            reqLoad,
  input  logic [LANES-1:0][SEQ_W-1:0] reqSeq,
  input  logic [LANES-1:0]            olderPending,
  output logic [LANES-1:0]            laneGrant,
  output issueStrobes_t               strobes
);
  localparam int RANK_W = LANE_ID_W + 1;

  logic [LANES-1:0] eligible;
  logic [RANK_W-1:0] rank [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++)
      eligible[i] = reqValid[i] && !flush && !(reqLoad[i] && olderPending[i]);
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rank[i] = '0;
      for (int j = 0; j < LANES; j++)
        if (j != i && eligible[j] && seqOlder(32'(reqSeq[j]), 32'(reqSeq[i]), SEQ_W))
          rank[i] = rank[i] + 1'b1;
    end
  end

  always_comb begin
    laneGrant = '0;
    strobes   = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int p = 0; p < ISSUE_PORTS; p++) begin
        if (eligible[i] && rank[i] == RANK_W'(p)) begin
          laneGrant[i]        = 1'b1;
          strobes.take[p]     = 1'b1;
          strobes.fromLane[p] = LANE_ID_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/load_issue_dp.sv
module load_issue_dp
  import load_issue_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int SEQ_W  = 5,
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  issueStrobes_t                       strobes,
  input  logic [LANES-1:0]                    reqLoad,
  input  logic [LANES-1:0][SEQ_W-1:0]         reqSeq,
  input  logic [LANES-1:0][ADDR_W-1:0]        reqAddr,
  input  logic [LANES-1:0][DATA_W-1:0]        reqData,
  output logic [ISSUE_PORTS-1:0]              portValid,
  output logic [ISSUE_PORTS-1:0]              portWrite,
  output logic [ISSUE_PORTS-1:0][ADDR_W-1:0]  portAddr,
  output logic [ISSUE_PORTS-1:0][DATA_W-1:0]  portData,
  output logic [ISSUE_PORTS-1:0][SEQ_W-1:0]   portSeq
);
  for (genvar p = 0; p < ISSUE_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        portValid[p] <= 1'b0;
        portWrite[p] <= 1'b0;
        portAddr[p]  <= '0;
        portData[p]  <= '0;
        portSeq[p]   <= '0;
      end else begin
        portValid[p] <= strobes.take[p];
        if (strobes.take[p]) begin
          portWrite[p] <= !reqLoad[strobes.fromLane[p]];
          portAddr[p]  <= reqAddr[strobes.fromLane[p]];
          portData[p]  <= reqData[strobes.fromLane[p]];
          portSeq[p]   <= reqSeq[strobes.fromLane[p]];
        end
      end
    end
  end
endmodule

// File: rtl/load_issue_arb.sv
module load_issue_arb
  import load_issue_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int SEQ_W  = 5,
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                flush,
  input  logic [LANES-1:0]                    allocValid,
  input  logic [LANES-1:0][SEQ_W-1:0]         allocSeq,
  input  logic [LANES-1:0]                    reqValid,
  input  logic [LANES-1:0]                    reqLoad,
  input  logic [LANES-1:0][SEQ_W-1:0]         reqSeq,
  input  logic [LANES-1:0][ADDR_W-1:0]        reqAddr,
  input  logic [LANES-1:0][DATA_W-1:0]        reqData,
  output logic [LANES-1:0]                    laneGrant,
  output logic [ISSUE_PORTS-1:0]              portValid,
  output logic [ISSUE_PORTS-1:0]              portWrite,
  output logic [ISSUE_PORTS-1:0][ADDR_W-1:0]  portAddr,
  output logic [ISSUE_PORTS-1:0][DATA_W-1:0]  portData,
  output logic [ISSUE_PORTS-1:0][SEQ_W-1:0]   portSeq
);
  logic [LANES-1:0] olderPending;
  issueStrobes_t    strobes;

  load_issue_pend #(.LANES(LANES), .SEQ_W(SEQ_W)) pend_i (
    .clk(clk), .rst(rst), .flush(flush),
    .allocValid(allocValid), .allocSeq(allocSeq),
    .reqValid(reqValid), .reqSeq(reqSeq),
    .olderPending(olderPending)
  );

  load_issue_ctrl #(.LANES(LANES), .SEQ_W(SEQ_W)) ctrl_i (
    .flush(flush), .reqValid(reqValid), .reqLoad(reqLoad), .reqSeq(reqSeq),
    .olderPending(olderPending), .laneGrant(laneGrant), .strobes(strobes)
  );

  load_issue_dp #(.LANES(LANES), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .reqLoad(reqLoad), .reqSeq(reqSeq), .reqAddr(reqAddr), .reqData(reqData),
    .portValid(portValid), .portWrite(portWrite), .portAddr(portAddr),
    .portData(portData), .portSeq(portSeq)
  );
endmodule

// File: rtl/load_issue_arb_chk.sv
module load_issue_arb_chk
  import load_issue_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SEQ_W = 5
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               flush,
  input logic [LANES-1:0]                   reqValid,
  input logic [LANES-1:0]                   reqLoad,
  input logic [LANES-1:0][SEQ_W-1:0]        reqSeq,
  input logic [LANES-1:0]                   laneGrant,
  input logic [ISSUE_PORTS-1:0]             portValid,
  input logic [ISSUE_PORTS-1:0][SEQ_W-1:0]  portSeq
);
  logic loadOrderBad;

  always_comb begin
    loadOrderBad = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < LANES; j++)
        if (laneGrant[i] && reqLoad[i] && reqValid[j] && reqLoad[j] && !laneGrant[j]
            && seqOlder(32'(reqSeq[j]), 32'(reqSeq[i]), SEQ_W))
          loadOrderBad = 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (portValid == '0));

  // R2
  grant_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(laneGrant) <= ISSUE_PORTS);

  // R2
  issue_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(portValid) == $past($countones(laneGrant))));

  // R3
  port_age_chk: assert property (@(posedge clk) disable iff (rst)
    (&portValid) |-> seqOlder(32'(portSeq[0]), 32'(portSeq[1]), SEQ_W));

  // R3
  port_fill_chk: assert property (@(posedge clk) disable iff (rst)
    portValid[1] |-> portValid[0]);

  // R5
  load_order_chk: assert property (@(posedge clk) disable iff (rst) !loadOrderBad);

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (laneGrant == '0));
endmodule

bind load_issue_arb load_issue_arb_chk #(.LANES(LANES), .SEQ_W(SEQ_W)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .reqValid(reqValid), .reqLoad(reqLoad),
  .reqSeq(reqSeq), .laneGrant(laneGrant), .portValid(portValid), .portSeq(portSeq)
);

// File: tb/load_issue_arb_tb_top.sv
`timescale 1ns/1ps
module load_issue_arb_tb_top;
  localparam int LANES = 3, SEQ_W = 5, ADDR_W = 48, DATA_W = 64, PORTS = 2;

  logic clk = 1'b0;
  logic rst, flush;
  logic [LANES-1:0] allocValid, reqValid, reqLoad, laneGrant;
  logic [LANES-1:0][SEQ_W-1:0] allocSeq, reqSeq;
  logic [LANES-1:0][ADDR_W-1:0] reqAddr;
  logic [LANES-1:0][DATA_W-1:0] reqData;
  logic [PORTS-1:0] portValid, portWrite;
  logic [PORTS-1:0][ADDR_W-1:0] portAddr;
  logic [PORTS-1:0][DATA_W-1:0] portData;
  logic [PORTS-1:0][SEQ_W-1:0] portSeq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  load_issue_arb #(.LANES(LANES), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .allocValid(allocValid), .allocSeq(allocSeq),
    .reqValid(reqValid), .reqLoad(reqLoad), .reqSeq(reqSeq), .reqAddr(reqAddr),
    .reqData(reqData), .laneGrant(laneGrant), .portValid(portValid), .portWrite(portWrite),
    .portAddr(portAddr), .portData(portData), .portSeq(portSeq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input int lane, input logic isLoad, input logic [SEQ_W-1:0] seq,
                       input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data);
    reqValid[lane] = 1'b1;
    reqLoad[lane]  = isLoad;
    reqSeq[lane]   = seq;
    reqAddr[lane]  = addr;
    reqData[lane]  = data;
  endtask

  task automatic allocOne(input int lane, input logic [SEQ_W-1:0] seq);
    allocValid[lane] = 1'b1;
    allocSeq[lane]   = seq;
    tick();
    allocValid = '0;
  endtask

  task automatic testReset();
    rst = 1'b1; flush = 1'b0;
    allocValid = '0; allocSeq = '0; reqValid = '0; reqLoad = '0;
    reqSeq = '0; reqAddr = '0; reqData = '0;
    repeat (3) tick();
    check("R1 ports idle in reset", 64'(portValid), 64'h0);
    rst = 1'b0;
    #1;
    check("R1 grants idle after reset", 64'(laneGrant), 64'h0);
    tick();
    check("R1 ports idle after reset", 64'(portValid), 64'h0);
  endtask

  task automatic testTwoWrites();
    offer(0, 1'b0, 5'd3, 48'h0000_1000_00A0, 64'hD0D0_0000_1111_2222);
    offer(1, 1'b0, 5'd2, 48'h0000_2000_00B0, 64'hD1D1_0000_3333_4444);
    #1;
    check("R4 two writes granted", 64'(laneGrant), 64'h3);
    tick();
    check("R2 both ports valid", 64'(portValid), 64'h3);
    check("R3 port0 older seq", 64'(portSeq[0]), 64'd2);
    check("R3 port1 younger seq", 64'(portSeq[1]), 64'd3);
    check("R10 port0 addr", 64'(portAddr[0]), 64'h0000_2000_00B0);
    check("R10 port1 data", portData[1], 64'hD0D0_0000_1111_2222);
    check("R10 write flags", 64'(portWrite), 64'h3);
    reqValid = '0;
    tick();
    check("R2 ports idle with no grants", 64'(portValid), 64'h0);
  endtask

  task automatic testPendingBlock();
    allocOne(2, 5'd4);
    offer(0, 1'b1, 5'd5, 48'h0000_0000_5550, 64'h0);
    offer(1, 1'b0, 5'd6, 48'h0000_0000_6660, 64'hABCD);
    #1;
    check("R5 read blocked, R6 write passes", 64'(laneGrant), 64'h2);
    tick();
    check("R6 single port valid", 64'(portValid), 64'h1);
    check("R6 write seq on port0", 64'(portSeq[0]), 64'd6);
    reqValid[1] = 1'b0;
    offer(2, 1'b1, 5'd4, 48'h0000_0000_4440, 64'h0);
    #1;
    check("R5 resolved, both reads granted", 64'(laneGrant), 64'h5);
    tick();
    check("R4 two reads on ports", 64'(portValid), 64'h3);
    check("R5 older read on port0", 64'(portSeq[0]), 64'd4);
    check("R5 younger read on port1", 64'(portSeq[1]), 64'd5);
    check("R10 read flags", 64'(portWrite), 64'h0);
    check("R10 port1 addr", 64'(portAddr[1]), 64'h0000_0000_5550);
    reqValid = '0;
    tick();
  endtask

  task automatic testThreeEligible();
    offer(2, 1'b1, 5'd7, 48'h70, 64'h0);
    offer(0, 1'b1, 5'd8, 48'h80, 64'h0);
    offer(1, 1'b0, 5'd9, 48'h90, 64'h9999);
    #1;
    check("R7 two oldest granted", 64'(laneGrant), 64'h5);
    tick();
    check("R7 port0 oldest", 64'(portSeq[0]), 64'd7);
    check("R7 port1 second", 64'(portSeq[1]), 64'd8);
    reqValid[2] = 1'b0; reqValid[0] = 1'b0;
    #1;
    check("R7 youngest granted later", 64'(laneGrant), 64'h2);
    tick();
    check("R7 youngest on port0", 64'(portSeq[0]), 64'd9);
    check("R4 mixed pair write flag", 64'(portWrite), 64'h1);
    reqValid = '0;
    tick();
  endtask

  task automatic testWrapAndFlush();
    offer(0, 1'b1, 5'b10000, 48'hA00, 64'h0);
    offer(1, 1'b1, 5'b01111, 48'hB00, 64'h0);
    #1;
    check("R8 both granted across wrap", 64'(laneGrant), 64'h3);
    tick();
    check("R8 pre-wrap seq on port0", 64'(portSeq[0]), 64'b01111);
    check("R8 post-wrap seq on port1", 64'(portSeq[1]), 64'b10000);
    reqValid = '0;
    allocOne(2, 5'b10001);
    offer(0, 1'b1, 5'b10010, 48'hC00, 64'h0);
    #1;
    check("R8 blocked by older pending", 64'(laneGrant), 64'h0);
    tick();
    check("R5 blocked read stays off ports", 64'(portValid), 64'h0);
    flush = 1'b1;
    #1;
    check("R9 no grant in flush cycle", 64'(laneGrant), 64'h0);
    tick();
    flush = 1'b0;
    check("R9 ports idle after flush cycle", 64'(portValid), 64'h0);
    #1;
    check("R9 table cleared, read granted", 64'(laneGrant), 64'h1);
    tick();
    check("R9 read issued after flush", 64'(portSeq[0]), 64'b10010);
    reqValid = '0;
    tick();
  endtask

  initial begin
    testReset();
    testTwoWrites();
    testPendingBlock();
    testThreeEligible();
    testWrapAndFlush();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule